// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block divides an oscillator clock-enable into a one-second tick and trims the average rate digitally. The oscillator enable nominally arrives at 32,768 Hz. A repeating window of 64 minutes is tracked. During the early part of that window, the first second of each minute can be made shorter or longer by a fixed number of oscillator ticks. A signed calibration value picks how many minutes are trimmed and in which direction.

The calibration value has a 5-bit magnitude N and a direction bit. A value of N trims the first 2·N minutes of each window, so at most 62 minutes are trimmed. With the direction bit set, each trimmed second is shortened by 256 ticks, which makes the clock gain about +4.07 ppm per step. With the bit clear, each trimmed second is lengthened by 128 ticks, which makes the clock lose about −2.03 ppm per step.

The value is captured on the first accepted oscillator tick of every window. A change made part-way through a window therefore applies from the next window. A stop input freezes the whole divider chain. Every count, length and step size is a parameter, so a bench can shrink the window.

Top module: `calibrated_prescaler`

## Requirements
- R1: After reset, `sec_tick` and `min_tick` are low. The first second then starts from tick zero at minute 0, second 0 of a new window.
- R2: With magnitude 0, every second lasts exactly `TICKS_PER_SEC` accepted oscillator ticks.
- R3: With `cal_pos`=1 and magnitude N, the first second (index 0) of minutes 0 to 2N−1 lasts `TICKS_PER_SEC − SHORT_TICKS` accepted ticks.
- R4: With `cal_pos`=0 and magnitude N, the first second of minutes 0 to 2N−1 lasts `TICKS_PER_SEC + LONG_TICKS` accepted ticks.
- R5: Only these seconds keep the nominal length: seconds with index other than 0, and every second of minutes 2N and later. This includes minutes 62 and 63 when N=31.
- R6: `min_tick` pulses together with the `sec_tick` that ends the last second (index `SECS_PER_MIN`−1) of each minute, and at no other time.
- R7: `cal_mag` and `cal_pos` are sampled on the first accepted tick of each window. A change part-way through a window does not alter any second of that window.
- R8: While `stop` is high, no counter advances and `sec_tick` and `min_tick` stay low. Counting resumes where it stopped.
- R9: A cycle with `osc_en` low does not advance the divider.
- R10: `sec_tick` is a single-clock pulse. It rises one clock after the accepted tick that completes a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_en | input | 1 | One-clock enable per oscillator period |
| stop | input | 1 | Freezes the divider while high |
| cal_mag | input | MAG_W | Calibration magnitude N |
| cal_pos | input | 1 | 1 = shorten trimmed seconds, 0 = lengthen them |
| sec_tick | output | 1 | One-second pulse |
| min_tick | output | 1 | Minute-boundary pulse, coincident with a sec_tick |

## Verification
The hardest case to reach is the capture point of the calibration value. The bench has to show that a change made mid-window is invisible until the window wraps, and that minutes 62 and 63 stay untrimmed at full magnitude. The bench shrinks the second and minute lengths, keeps the 64-minute window and the 5-bit magnitude, and runs three full windows back to back. It rewrites the calibration inputs halfway through the first and second windows. The scoreboard expects every second of a window to follow the value present at that window's start. A gappy `osc_en` pattern and a stop burst inside the last window check that only accepted ticks are counted.

// File: rtl/cps_pkg.sv
package cps_pkg;
  // Length class selected for the second currently being counted.
  typedef enum logic [1:0] {
    LEN_NOM   = 2'd0,
    LEN_SHORT = 2'd1,
    LEN_LONG  = 2'd2
  } len_e;
endpackage

// File: rtl/cps_tick_div.sv
module cps_tick_div
  import cps_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SHORT_TICKS   = 256,
  parameter int LONG_TICKS    = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  len_e sel,
  output logic at_zero,
  output logic wrap
);
  localparam int TW = $clog2(TICKS_PER_SEC + LONG_TICKS + 1);
  localparam logic [TW-1:0] LAST_NOM   = TW'(TICKS_PER_SEC - 1);
  localparam logic [TW-1:0] LAST_SHORT = TW'(TICKS_PER_SEC - SHORT_TICKS - 1);
  localparam logic [TW-1:0] LAST_LONG  = TW'(TICKS_PER_SEC + LONG_TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d, last;

  always_comb begin
    unique case (sel)
      LEN_SHORT: last = LAST_SHORT;
      LEN_LONG:  last = LAST_LONG;
      default:   last = LAST_NOM;
    endcase
  end

  assign wrap    = adv && (cnt_q == last);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cps_pos_ctr.sv
module cps_pos_ctr #(
  parameter int SECS_PER_MIN = 60,
  parameter int MINS_PER_WIN = 64,
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1,
  localparam int MW = (MINS_PER_WIN > 1) ? $clog2(MINS_PER_WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_adv,
  output logic [SW-1:0] sec_idx,
  output logic [MW-1:0] min_idx,
  output logic          min_wrap,
  output logic          win_start
);
  localparam logic [SW-1:0] SEC_LAST = SW'(SECS_PER_MIN - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(MINS_PER_WIN - 1);

  logic [SW-1:0] sec_q, sec_d;
  logic [MW-1:0] min_q, min_d;

  assign min_wrap  = sec_adv && (sec_q == SEC_LAST);
  assign win_start = (sec_q == '0) && (min_q == '0);
  assign sec_idx   = sec_q;
  assign min_idx   = min_q;

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    if (sec_adv) begin
      if (min_wrap) begin
        sec_d = '0;
        min_d = (min_q == MIN_LAST) ? '0 : min_q + MW'(1);
      end else begin
        sec_d = sec_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
    end
  end
endmodule

// File: rtl/cps_trim.sv
module cps_trim
  import cps_pkg::*;
#(
  parameter int MAG_W = 5,
  parameter int MW    = 6,
  parameter int SW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  input  logic [SW-1:0]    sec_idx,
  input  logic [MW-1:0]    min_idx,
  output len_e             sel
);
  localparam int CW = (MW > MAG_W + 1) ? MW : MAG_W + 1;

  logic [MAG_W-1:0] mag_q, mag_d;
  logic             pos_q, pos_d;
  logic [CW-1:0]    min_ext, span;
  logic             trim_now;

  always_comb begin
    mag_d = mag_q;
    pos_d = pos_q;
    if (load) begin
      mag_d = cal_mag;
      pos_d = cal_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      pos_q <= 1'b0;
    end else begin
      mag_q <= mag_d;
      pos_q <= pos_d;
    end
  end

  assign min_ext  = CW'(min_idx);
  assign span     = CW'({mag_q, 1'b0});
  assign trim_now = (sec_idx == '0) && (min_ext < span);

  always_comb begin
    if (!trim_now)  sel = LEN_NOM;
    else if (pos_q) sel = LEN_SHORT;
    else            sel = LEN_LONG;
  end
endmodule

// File: rtl/calibrated_prescaler.sv
module calibrated_prescaler
  import cps_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SHORT_TICKS   = 256,
  parameter int LONG_TICKS    = 128,
  parameter int SECS_PER_MIN  = 60,
  parameter int MINS_PER_WIN  = 64,
  parameter int MAG_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             sec_tick,
  output logic             min_tick
);
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam int MW = (MINS_PER_WIN > 1) ? $clog2(MINS_PER_WIN) : 1;

  logic          adv, tick_zero, sec_wrap, min_wrap, win_start, load;
  logic [SW-1:0] sec_idx;
  logic [MW-1:0] min_idx;
  len_e          sel;
  logic          sec_q, min_q;

  assign adv  = osc_en && !stop;
  assign load = adv && tick_zero && win_start;

  cps_tick_div #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SHORT_TICKS  (SHORT_TICKS),
    .LONG_TICKS   (LONG_TICKS)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .sel    (sel),
    .at_zero(tick_zero),
    .wrap   (sec_wrap)
  );

  cps_pos_ctr #(
    .SECS_PER_MIN(SECS_PER_MIN),
    .MINS_PER_WIN(MINS_PER_WIN)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_adv  (sec_wrap),
    .sec_idx  (sec_idx),
    .min_idx  (min_idx),
    .min_wrap (min_wrap),
    .win_start(win_start)
  );

  cps_trim #(
    .MAG_W(MAG_W),
    .MW   (MW),
    .SW   (SW)
  ) u_trim (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .cal_mag(cal_mag),
    .cal_pos(cal_pos),
    .sec_idx(sec_idx),
    .min_idx(min_idx),
    .sel    (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 1'b0;
      min_q <= 1'b0;
    end else begin
      sec_q <= sec_wrap;
      min_q <= min_wrap;
    end
  end

  assign sec_tick = sec_q;
  assign min_tick = min_q;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LONG_TICKS    = 128
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic stop,
  input logic sec_tick,
  input logic min_tick
);
  localparam int GW = $clog2(TICKS_PER_SEC + LONG_TICKS + 2) + 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(TICKS_PER_SEC + LONG_TICKS);

  logic [GW-1:0] gap_q;
  logic          acc;

  assign acc = osc_en && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (sec_tick) gap_q <= acc ? GW'(1) : '0;
    else if (acc)      gap_q <= gap_q + GW'(1);
  end

  // R6
  min_with_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick |-> sec_tick);

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sec_tick && !min_tick));

  // R9
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !sec_tick);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R4
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_MAX);
endmodule

bind calibrated_prescaler cps_checker #(
  .TICKS_PER_SEC(TICKS_PER_SEC),
  .LONG_TICKS   (LONG_TICKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .osc_en  (osc_en),
  .stop    (stop),
  .sec_tick(sec_tick),
  .min_tick(min_tick)
);

// File: tb/calibrated_prescaler_bench.sv
module calibrated_prescaler_bench;
  localparam int TPS   = 64;
  localparam int SHORT = 16;
  localparam int LONG  = 8;
  localparam int SPM   = 3;
  localparam int MPW   = 64;

  typedef struct {
    int    len;
    bit    mn;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       stop = 1'b0;
  logic [4:0] cal_mag = '0;
  logic       cal_pos = 1'b0;
  logic       sec_tick, min_tick;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   acc_cnt = 0;
  bit   running = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  calibrated_prescaler #(
    .TICKS_PER_SEC(TPS), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG),
    .SECS_PER_MIN(SPM), .MINS_PER_WIN(MPW), .MAG_W(5)
  ) u_calibrated_prescaler (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .cal_mag(cal_mag), .cal_pos(cal_pos),
    .sec_tick(sec_tick), .min_tick(min_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected lengths for one whole window under a captured value.
  task automatic push_window(input int mag, input bit pos);
    for (int m = 0; m < MPW; m++) begin
      for (int s = 0; s < SPM; s++) begin
        exp_t e;
        if (s == 0 && m < 2 * mag) begin
          e.len = pos ? TPS - SHORT : TPS + LONG;
          e.req = pos ? "R3" : "R4";
        end else begin
          e.len = TPS;
          e.req = (mag == 0) ? "R2" : "R5";
        end
        e.mn = (s == SPM - 1);
        q.push_back(e);
      end
    end
  endtask

  // Gappy oscillator enable (R9): three of every four clocks.
  always @(negedge clk) begin : osc_gen
    int k;
    if (running) begin
      k = $urandom_range(0, 3);
      osc_en <= (k != 3);
    end
  end

  // Count accepted ticks at the edge where the design consumes them.
  always @(posedge clk) begin
    if (running && osc_en && !stop) acc_cnt++;
  end

  // Monitor: compare each produced second with the scoreboard.
  always @(negedge clk) begin : mon
    static bit prev_sec = 1'b0;
    if (running) begin
      if (prev_sec) check(!sec_tick, "R10", sec_tick, 0);
      if (stop) check(!sec_tick && !min_tick, "R8", sec_tick, 0);
      if (min_tick && !sec_tick) check(1'b0, "R6", min_tick, 0);
      if (sec_tick) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(acc_cnt == e.len, e.req, acc_cnt, e.len);
          check(min_tick == e.mn, "R6", min_tick, e.mn);
        end
        acc_cnt = 0;
      end
      prev_sec = sec_tick;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!sec_tick && !min_tick, "R1", sec_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sec_tick && !min_tick, "R1", min_tick, 0);

    // Window 1: +3, then change input mid-window (R7)
    cal_mag = 5'd3;
    cal_pos = 1'b1;
    push_window(3, 1'b1);
    running = 1'b1;
    wait (q.size() < 100);
    @(negedge clk);
    cal_mag = 5'd31;
    cal_pos = 1'b0;
    wait (q.size() == 0);

    // Window 2: -31 captured at window start, reaches minutes 62/63 (R5, R7)
    push_window(31, 1'b0);
    wait (q.size() < 100);
    @(negedge clk);
    cal_mag = 5'd0;
    cal_pos = 1'b1;
    wait (q.size() == 0);

    // Window 3: magnitude 0, with a stop burst (R2, R8)
    push_window(0, 1'b1);
    wait (q.size() < 150);
    @(negedge clk);
    stop = 1'b1;
    repeat (40) @(negedge clk);
    stop = 1'b0;
    wait (q.size() == 0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule